// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable integer N and emits one single-cycle pulse per N input clocks. It forms N from a two-modulus prescaler that counts either P or P+1 input clocks per output tick, plus two down-counters: a swallow count A and a main count B. While the swallow count is nonzero, each prescaler cycle is one clock longer. The result is N = B·P + A, in steps of one input clock.

The prescaler has a fixed divide-by-4/5 core. An extension counter runs that core 2, 4, 8 or 16 times per prescaler cycle, which gives the four selectable lower moduli P of 8, 16, 32 and 64. The core counts to five at most once per prescaler cycle, in its final pass, and only when the high modulus is requested.

A new configuration is offered with a one-cycle load strobe. A legal setting is held as pending and takes effect at the next output-period boundary. An illegal setting is refused, raises an error flag and leaves the configuration unchanged. A separate flag marks active settings whose ratio falls below the contiguous-range limit. The control pins are plain strobes and levels. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `psw_divider`

## Requirements
- R1: `div_pulse` occurs exactly once every N = B·P + A input clocks, where B is the active main count, A the active swallow count and P the active lower modulus.
- R2: `cfg_psel` encodes the lower modulus: 0 selects P=8, 1 selects P=16, 2 selects P=32 and 3 selects P=64.
- R3: `div_pulse` is high for exactly one input clock per period.
- R4: Each prescaler cycle lasts P+1 clocks while the swallow count is nonzero and P clocks once it is zero. The 4/5 core counts to five only in the last core pass of a P+1 cycle.
- R5: The edge cases A=0 and A=B give periods of B·P and B·(P+1).
- R6: A load with `cfg_main` below 3, or with `cfg_swallow` greater than `cfg_main`, sets `cfg_err` on the next cycle. The previously active period length is kept.
- R7: An accepted load clears `cfg_err` on the next cycle. The smallest legal main count, 3, is accepted.
- R8: An accepted load changes nothing in the period in progress. The new ratio applies from the first full period after the next `div_pulse`.
- R9: `cfg_slow` is 1 exactly when the active ratio N is below P·P − P, and 0 otherwise. It updates in the same cycle as the pulse that starts the new setting.
- R10: After reset, `div_pulse` and `cfg_err` are 0, the setting is P=8, A=0, B=3 (N=24), and `cfg_slow` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe offering a new setting |
| cfg_psel | input | 2 | Prescaler pair select (0:8/9, 1:16/17, 2:32/33, 3:64/65) |
| cfg_swallow | input | 6 | Swallow count A, 0 to 63 |
| cfg_main | input | 13 | Main count B, 3 to 8191 |
| div_pulse | output | 1 | One-clock pulse per output period |
| cfg_err | output | 1 | Last offered setting was refused |
| cfg_slow | output | 1 | Active ratio lies below the contiguous-range limit |

## Verification
On every cycle, the assertions check the following. The core reaches its fifth count only in the last pass of a high-modulus prescaler cycle. The swallow count never exceeds the main count, and the main count never sits at zero. The output pulse never lasts two cycles. The active setting moves only on a period boundary. A refused load keeps the pending setting and raises the error flag, and an accepted load clears it. Exact period lengths for each prescaler pair can only be shown by the bench's scenarios. The same holds for the A=0 and A=B extremes, the old length finishing before a reload takes hold, and a refused setting leaving the measured period unchanged. The bench measures these as intervals between pulses.

// File: rtl/psw_pkg.sv
package psw_pkg;

  // Lower-modulus select: P = 8 << select
  typedef enum logic [1:0] {
    PSEL_8  = 2'd0,
    PSEL_16 = 2'd1,
    PSEL_32 = 2'd2,
    PSEL_64 = 2'd3
  } psel_e;

  localparam int unsigned CORE_LO = 4;  // low count of the 4/5 core

  // number of core passes per prescaler cycle
  function automatic int unsigned ext_count(psel_e s);
    return 32'd2 << int'(s);
  endfunction

  // lower modulus P
  function automatic int unsigned low_mod(psel_e s);
    return CORE_LO * ext_count(s);
  endfunction

endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler
  import psw_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int CORE_W = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  psel_e psel,
  input  logic  mod_hi,
  output logic  pre_tick
);

  localparam logic [CORE_W-1:0] CORE_FOUR = CORE_W'(CORE_LO - 1);
  localparam logic [CORE_W-1:0] CORE_FIVE = CORE_W'(CORE_LO);

  logic [CORE_W-1:0] core_q;
  logic [EXT_W-1:0]  ext_q;
  logic [EXT_W-1:0]  ext_last;
  logic [CORE_W-1:0] core_last;
  logic              last_pass;

  always_comb begin
    ext_last  = EXT_W'(ext_count(psel) - 1);
    last_pass = (ext_q == ext_last);
    core_last = (mod_hi && last_pass) ? CORE_FIVE : CORE_FOUR;
    pre_tick  = last_pass && (core_q == core_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_q <= '0;
      ext_q  <= '0;
    end else if (pre_tick) begin
      core_q <= '0;
      ext_q  <= '0;
    end else if (core_q == core_last) begin
      core_q <= '0;
      ext_q  <= ext_q + 1'b1;
    end else begin
      core_q <= core_q + 1'b1;
    end
  end

  // R4: a fifth core count only in the final pass of a P+1 cycle
  p_five_in_last_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_q == CORE_FIVE) |-> (mod_hi && ext_q == ext_last));

endmodule

// File: rtl/psw_swallow.sv
module psw_swallow #(
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int DEF_A = 0,
  parameter int DEF_B = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_tick,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  output logic           mod_hi,
  output logic           period_end,
  output logic           div_pulse
);

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;

  always_comb begin
    mod_hi     = (a_q != '0);
    period_end = pre_tick && (b_q == B_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q       <= A_W'(DEF_A);
      b_q       <= B_W'(DEF_B);
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= period_end;
      if (period_end) begin
        a_q <= ld_a;
        b_q <= ld_b;
      end else if (pre_tick) begin
        b_q <= b_q - 1'b1;
        if (a_q != '0) a_q <= a_q - 1'b1;
      end
    end
  end

  // R5: swallow count never overtakes main count
  p_a_within_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ({{(B_W-A_W){1'b0}}, a_q} <= b_q));
  // R1: main count never rests at zero
  p_b_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q != '0));
  // R3: single-cycle output
  p_pulse_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

endmodule

// File: rtl/psw_cfg.sv
module psw_cfg
  import psw_pkg::*;
#(
  parameter int    A_W      = 6,
  parameter int    B_W      = 13,
  parameter int    B_MIN    = 3,
  parameter psel_e DEF_PSEL = PSEL_8,
  parameter int    DEF_A    = 0,
  parameter int    DEF_B    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [1:0]     cfg_psel,
  input  logic [A_W-1:0] cfg_swallow,
  input  logic [B_W-1:0] cfg_main,
  input  logic           period_end,
  output psel_e          act_psel,
  output logic [A_W-1:0] pend_a,
  output logic [B_W-1:0] pend_b,
  output logic           cfg_err,
  output logic           cfg_slow
);

  psel_e          pend_psel;
  logic [A_W-1:0] act_a;
  logic [B_W-1:0] act_b;
  logic           bad_in;
  logic [31:0]    p_val, n_val, lim_val;

  always_comb begin
    bad_in = (cfg_main < B_W'(B_MIN)) ||
             ({{(B_W-A_W){1'b0}}, cfg_swallow} > cfg_main);
    p_val   = low_mod(act_psel);
    n_val   = 32'(act_b) * p_val + 32'(act_a);
    lim_val = p_val * p_val - p_val;
    cfg_slow = (n_val < lim_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_psel <= DEF_PSEL;
      pend_a    <= A_W'(DEF_A);
      pend_b    <= B_W'(DEF_B);
      act_psel  <= DEF_PSEL;
      act_a     <= A_W'(DEF_A);
      act_b     <= B_W'(DEF_B);
      cfg_err   <= 1'b0;
    end else begin
      if (cfg_load) begin
        if (bad_in) begin
          cfg_err <= 1'b1;
        end else begin
          cfg_err   <= 1'b0;
          pend_psel <= psel_e'(cfg_psel);
          pend_a    <= cfg_swallow;
          pend_b    <= cfg_main;
        end
      end
      if (period_end) begin
        act_psel <= pend_psel;
        act_a    <= pend_a;
        act_b    <= pend_b;
      end
    end
  end

  // R6: refused setting leaves the pending setting alone and flags
  p_refuse_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && ((cfg_main < B_W'(B_MIN)) ||
                  ({{(B_W-A_W){1'b0}}, cfg_swallow} > cfg_main)))
    |=> (cfg_err && pend_a == $past(pend_a) && pend_b == $past(pend_b)
         && pend_psel == $past(pend_psel)));
  // R7: accepted setting clears the flag
  p_accept_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_main >= B_W'(B_MIN) &&
     {{(B_W-A_W){1'b0}}, cfg_swallow} <= cfg_main) |=> !cfg_err);
  // R8: active setting moves only on a period boundary
  p_boundary_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(act_a) && $stable(act_b) && $stable(act_psel)));

endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
#(
  parameter int    A_W      = 6,
  parameter int    B_W      = 13,
  parameter int    B_MIN    = 3,
  parameter psel_e DEF_PSEL = PSEL_8,
  parameter int    DEF_A    = 0,
  parameter int    DEF_B    = 3,
  parameter int    EXT_W    = 4,
  parameter int    CORE_W   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [1:0]     cfg_psel,
  input  logic [A_W-1:0] cfg_swallow,
  input  logic [B_W-1:0] cfg_main,
  output logic           div_pulse,
  output logic           cfg_err,
  output logic           cfg_slow
);

  psel_e          act_psel;
  logic [A_W-1:0] pend_a;
  logic [B_W-1:0] pend_b;
  logic           mod_hi;
  logic           pre_tick;
  logic           period_end;

  psw_cfg #(
    .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN),
    .DEF_PSEL(DEF_PSEL), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_psel(cfg_psel),
    .cfg_swallow(cfg_swallow), .cfg_main(cfg_main),
    .period_end(period_end),
    .act_psel(act_psel), .pend_a(pend_a), .pend_b(pend_b),
    .cfg_err(cfg_err), .cfg_slow(cfg_slow)
  );

  psw_prescaler #(.EXT_W(EXT_W), .CORE_W(CORE_W)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .psel(act_psel), .mod_hi(mod_hi), .pre_tick(pre_tick)
  );

  psw_swallow #(
    .A_W(A_W), .B_W(B_W), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_sw (
    .clk(clk), .rst_n(rst_n),
    .pre_tick(pre_tick), .ld_a(pend_a), .ld_b(pend_b),
    .mod_hi(mod_hi), .period_end(period_end), .div_pulse(div_pulse)
  );

endmodule

// File: tb/sim_psw_divider.sv
`timescale 1ns/1ps
module sim_psw_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_psel = '0;
  logic [5:0]  cfg_swallow = '0;
  logic [12:0] cfg_main = '0;
  logic        div_pulse, cfg_err, cfg_slow;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_pulse = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  psw_divider u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_psel(cfg_psel),
    .cfg_swallow(cfg_swallow), .cfg_main(cfg_main),
    .div_pulse(div_pulse), .cfg_err(cfg_err), .cfg_slow(cfg_slow)
  );

  // vector table: select, swallow, main, expected N, expected slow flag
  localparam int NV = 10;
  localparam int VP [NV] = '{0, 0, 0, 1, 1, 2, 2, 3, 3, 3};
  localparam int VA [NV] = '{5, 0, 9, 0, 17, 31, 0, 63, 0, 1};
  localparam int VB [NV] = '{7, 9, 9, 14, 20, 31, 30, 63, 62, 3};
  localparam int VN [NV] = '{61, 72, 81, 224, 337, 1023, 960, 4095, 3968, 193};
  localparam int VS [NV] = '{0, 0, 0, 1, 0, 0, 1, 0, 1, 1};

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int iv);
    do @(negedge clk); while (!div_pulse);
    iv = cyc - last_pulse;
    last_pulse = cyc;
  endtask

  task automatic load(input int ps, input int a, input int b);
    cfg_psel = 2'(ps);
    cfg_swallow = 6'(a);
    cfg_main = 13'(b);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int iv;
    int prev;
    repeat (3) @(negedge clk);
    chk("R10 pulse in reset", int'(div_pulse), 0);
    chk("R10 err in reset", int'(cfg_err), 0);
    chk("R10 slow in reset", int'(cfg_slow), 1);
    rst_n = 1'b1;
    wait_pulse(iv);
    wait_pulse(iv);
    chk("R10 default period", iv, 24);
    @(negedge clk);
    chk("R3 pulse one clock wide", int'(div_pulse), 0);
    prev = 24;

    for (int i = 0; i < NV; i++) begin
      wait_pulse(iv);
      load(VP[i], VA[i], VB[i]);
      chk("R7 err after accepted load", int'(cfg_err), 0);
      wait_pulse(iv);
      chk("R8 old period finishes", iv, prev);
      chk("R9 slow flag on new setting", int'(cfg_slow), VS[i]);
      wait_pulse(iv);
      chk("R1 R2 R4 R5 new period", iv, VN[i]);
      prev = VN[i];
    end

    // R6: main count below minimum
    load(0, 0, 2);
    chk("R6 err on short main", int'(cfg_err), 1);
    wait_pulse(iv);
    wait_pulse(iv);
    chk("R6 period kept after short main", iv, 193);
    // R6: swallow above main
    load(1, 10, 5);
    chk("R6 err on swallow over main", int'(cfg_err), 1);
    wait_pulse(iv);
    wait_pulse(iv);
    chk("R6 period kept after swallow over main", iv, 193);
    // R7 / R5: minimum main count with A=B
    load(0, 3, 3);
    chk("R7 err cleared at minimum main", int'(cfg_err), 0);
    wait_pulse(iv);
    chk("R8 old period before min setting", iv, 193);
    wait_pulse(iv);
    chk("R5 A=B at minimum main", iv, 27);
    chk("R9 slow flag at minimum main", int'(cfg_slow), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule